// File: doc/BRIEF.md
# Triggered Dual-Channel PWM Fader

This block drives two pulse-width-modulated outputs whose duty cycle fades between a low and a high 7-bit level each time a trigger input changes. A rising trigger sends both channels upward toward the high level. Channel 0 starts after its own delay, and channel 1 starts a further delay after channel 0. A falling trigger sends both channels down toward the low level at once. Each fade walks a perceptual square-law curve of 176 steps. The step rate is set by separate rise and fall slew values, counted on a prescaled time-base tick.

The parameters arrive on plain input words: low level, high level, frequency code, two slews and two delays. Two control bits, start and enable, gate the whole fader so that software can change the parameters while it is halted. A mode input selects programming mode, where the outputs are released, or standalone mode, where the outputs are driven.

Top module: `fader_top`

## Requirements
- R1: After reset every channel sits on step 0 with duty 0, both PWM outputs are low, and the output enable follows the mode input.
- R2: The duty of step k is floor(127*k*k/(175*175)) for k from 0 to 175, so a full fade crosses 176 steps, and duty is 0 for every step below 16.
- R3: A trigger rise (when running) moves each channel upward. It stops on the first step whose duty is at least the high level, taken from bits [6:0] of its word, or on step 175.
- R4: A trigger fall (when running) moves both channels downward at once. Each stops on the first step whose duty is at most the low level, taken from bits [6:0] of its word, or on step 0.
- R5: One PWM period is 127 slots. Each slot lasts DIV_UNIT*(32-code) clocks, where the code is bits [11:7] of the frequency word. The output is high for the first duty slots of the period, so duty 127 is always high.
- R6: A new duty value takes effect only at the start of a PWM period.
- R7: A tick occurs every TICK_DIV clocks. Each fade step lasts (slew+1) ticks, using the rise slew when moving up and the fall slew when moving down. A slew change takes effect within the current step.
- R8: After a rise, channel 0 starts after the channel-0 delay in ticks. Channel 1 starts after the sum of the channel-0 delay and the common delay. A fall cancels any start still pending.
- R9: The fader advances only while both start and enable are high. Otherwise all state is frozen, and trigger edges seen meanwhile are dropped rather than replayed later.
- R10: While the mode input is low, the output enable is low and both PWM outputs are low.
- R11: A trigger edge during a fade reverses the direction from the current step, not from an end point.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| mode_i | input | 1 | 1 = standalone (outputs driven), 0 = programming |
| run_start_i | input | 1 | Start control bit |
| run_en_i | input | 1 | Enable control bit |
| trig_i | input | 1 | Asynchronous trigger input |
| prm_lo_i | input | 16 | Low level word, bits [6:0] used |
| prm_hi_i | input | 16 | High level word, bits [6:0] used |
| prm_freq_i | input | 16 | Frequency word, code in bits [11:7] |
| prm_slew_up_i | input | 16 | Ticks per rising step minus one |
| prm_slew_dn_i | input | 16 | Ticks per falling step minus one |
| prm_dly0_i | input | 16 | Trigger-to-channel-0 delay in ticks |
| prm_dly_com_i | input | 16 | Channel-0-to-channel-1 delay in ticks |
| pwm_o | output | 2 | PWM outputs, channel 0 in bit 0 |
| pwm_oe_o | output | 1 | Output enable |

## Verification
The high level is swept over several values, including 1 and full scale, and the low level over several values. The settled high-time per period then shows whether the stop rule picks the first crossing step of the curve rather than the raw target. The period is timed between rising edges for several frequency codes, which separates the slot divider from the duty count. Staggered-delay, slow-slew and mid-fade reversal runs are sampled at instants where each channel must already have moved, or must not yet have moved. These runs separate the start order, the per-step time and the reverse-from-current behaviour from a restart at an end point. Halt and programming-mode runs show that frozen state and released outputs leave no trace on the pins.

// File: rtl/fader_pkg.sv
package fader_pkg;

   typedef enum logic [1:0] {
      DIR_HOLD = 2'd0,
      DIR_UP   = 2'd1,
      DIR_DOWN = 2'd2
   } fade_dir_e;

   // Duty for step k of an nsteps-long curve reaching dmax at the last step.
   function automatic int unsigned curve_duty(input int unsigned k,
                                              input int unsigned nsteps,
                                              input int unsigned dmax,
                                              input bit          square);
      int unsigned last;
      last = nsteps - 1;
      if (square)
         return (k * k * dmax) / (last * last);
      else
         return (k * dmax) / last;
   endfunction

endpackage

// File: rtl/fader_delay.sv
module fader_delay #(
   parameter int CW = 17
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          run,
   input  logic          tick,
   input  logic          arm,
   input  logic          cancel,
   input  logic [CW-1:0] dly,
   output logic          fire
);
   logic          pending_q;
   logic [CW-1:0] cnt_q;

   assign fire = run && pending_q && (cnt_q == '0) && !arm && !cancel;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         pending_q <= 1'b0;
         cnt_q     <= '0;
      end else if (run) begin
         if (cancel) begin
            pending_q <= 1'b0;
         end else if (arm) begin
            pending_q <= 1'b1;
            cnt_q     <= dly;
         end else if (pending_q) begin
            if (cnt_q == '0)
               pending_q <= 1'b0;
            else if (tick)
               cnt_q <= cnt_q - CW'(1);
         end
      end
   end

   // R8: a start is issued once per arming
   p_single_fire_r8: assert property (@(posedge clk) disable iff (!rst_n)
      fire |=> !fire);

endmodule

// File: rtl/fader_pwm.sv
module fader_pwm #(
   parameter int DUTY_W   = 7,
   parameter int FREQ_W   = 5,
   parameter int DIV_UNIT = 4
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic [FREQ_W-1:0] freq,
   input  logic [DUTY_W-1:0] duty_in,
   output logic              pwm
);
   localparam int DMAX   = (1 << DUTY_W) - 1;
   localparam int NCODES = 1 << FREQ_W;
   localparam int DIVW   = $clog2(DIV_UNIT * NCODES + 1);

   logic [DIVW-1:0]   div_q;
   logic [DIVW-1:0]   lim;
   logic              slot_en;
   logic              wrap;
   logic [DUTY_W-1:0] slot_q;
   logic [DUTY_W-1:0] duty_q;

   assign lim     = DIVW'(DIV_UNIT) * (DIVW'(NCODES) - DIVW'(freq)) - DIVW'(1);
   assign slot_en = (div_q >= lim);
   assign wrap    = slot_en && (slot_q == DUTY_W'(DMAX - 1));
   assign pwm     = (slot_q < duty_q);

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         div_q  <= '0;
         slot_q <= '0;
         duty_q <= '0;
      end else begin
         div_q <= slot_en ? '0 : div_q + DIVW'(1);
         if (slot_en) begin
            if (wrap) begin
               slot_q <= '0;
               duty_q <= duty_in;
            end else begin
               slot_q <= slot_q + DUTY_W'(1);
            end
         end
      end
   end

   // R6: the applied duty only moves at a period boundary
   p_duty_boundary_r6: assert property (@(posedge clk) disable iff (!rst_n)
      !wrap |=> $stable(duty_q));

endmodule

// File: rtl/fader_chan.sv
module fader_chan
   import fader_pkg::*;
#(
   parameter int NSTEPS       = 176,
   parameter int DUTY_W       = 7,
   parameter int SLEW_W       = 16,
   parameter bit CURVE_SQUARE = 1'b1
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              run,
   input  logic              tick,
   input  logic              go_up,
   input  logic              go_down,
   input  logic [SLEW_W-1:0] slew_up,
   input  logic [SLEW_W-1:0] slew_dn,
   input  logic [DUTY_W-1:0] tgt_hi,
   input  logic [DUTY_W-1:0] tgt_lo,
   output logic [DUTY_W-1:0] duty
);
   localparam int IDX_W = $clog2(NSTEPS);
   localparam int LAST  = NSTEPS - 1;
   localparam int DMAX  = (1 << DUTY_W) - 1;

   logic [DUTY_W-1:0] lut [NSTEPS];

   generate
      if (CURVE_SQUARE) begin : g_square
         for (genvar i = 0; i < NSTEPS; i++) begin : g_ent
            assign lut[i] = DUTY_W'(curve_duty(i, NSTEPS, DMAX, 1'b1));
         end
      end else begin : g_linear
         for (genvar i = 0; i < NSTEPS; i++) begin : g_ent
            assign lut[i] = DUTY_W'(curve_duty(i, NSTEPS, DMAX, 1'b0));
         end
      end
   endgenerate

   logic [IDX_W-1:0]  idx_q;
   fade_dir_e         dir_q;
   logic [SLEW_W-1:0] cnt_q;
   logic [SLEW_W-1:0] slew_sel;
   logic              at_hi, at_lo, step_due;

   assign duty     = lut[idx_q];
   assign slew_sel = (dir_q == DIR_UP) ? slew_up : slew_dn;
   assign at_hi    = (duty >= tgt_hi) || (idx_q == IDX_W'(LAST));
   assign at_lo    = (duty <= tgt_lo) || (idx_q == '0);
   assign step_due = (cnt_q >= slew_sel);

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         idx_q <= '0;
         dir_q <= DIR_HOLD;
         cnt_q <= '0;
      end else if (run) begin
         if (go_down) begin
            dir_q <= DIR_DOWN;
            cnt_q <= '0;
         end else if (go_up) begin
            dir_q <= DIR_UP;
            cnt_q <= '0;
         end else if (tick) begin
            unique case (dir_q)
               DIR_UP: begin
                  if (at_hi) begin
                     dir_q <= DIR_HOLD;
                     cnt_q <= '0;
                  end else if (step_due) begin
                     cnt_q <= '0;
                     idx_q <= idx_q + IDX_W'(1);
                  end else begin
                     cnt_q <= cnt_q + SLEW_W'(1);
                  end
               end
               DIR_DOWN: begin
                  if (at_lo) begin
                     dir_q <= DIR_HOLD;
                     cnt_q <= '0;
                  end else if (step_due) begin
                     cnt_q <= '0;
                     idx_q <= idx_q - IDX_W'(1);
                  end else begin
                     cnt_q <= cnt_q + SLEW_W'(1);
                  end
               end
               default: cnt_q <= '0;
            endcase
         end
      end
   end

   // R2: the step index stays on the curve
   p_idx_range_r2: assert property (@(posedge clk) disable iff (!rst_n)
      idx_q <= IDX_W'(LAST));

   // R11: a reversal continues from the current step, one step at a time
   p_step_unit_r11: assert property (@(posedge clk) disable iff (!rst_n)
      (idx_q == $past(idx_q)) || (idx_q == $past(idx_q) + IDX_W'(1)) ||
      (idx_q == $past(idx_q) - IDX_W'(1)));

   // R9: nothing moves while halted
   p_halt_r9: assert property (@(posedge clk) disable iff (!rst_n)
      !run |=> $stable(idx_q) && $stable(dir_q));

endmodule

// File: rtl/fader_top.sv
module fader_top #(
   parameter int WORD_W       = 16,
   parameter int DUTY_W       = 7,
   parameter int FREQ_W       = 5,
   parameter int FREQ_LSB     = 7,
   parameter int SLEW_W       = 16,
   parameter int DLY_W        = 16,
   parameter int NSTEPS       = 176,
   parameter int TICK_DIV     = 1000,
   parameter int DIV_UNIT     = 4,
   parameter bit CURVE_SQUARE = 1'b1
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              mode_i,
   input  logic              run_start_i,
   input  logic              run_en_i,
   input  logic              trig_i,
   input  logic [WORD_W-1:0] prm_lo_i,
   input  logic [WORD_W-1:0] prm_hi_i,
   input  logic [WORD_W-1:0] prm_freq_i,
   input  logic [SLEW_W-1:0] prm_slew_up_i,
   input  logic [SLEW_W-1:0] prm_slew_dn_i,
   input  logic [DLY_W-1:0]  prm_dly0_i,
   input  logic [DLY_W-1:0]  prm_dly_com_i,
   output logic [1:0]        pwm_o,
   output logic              pwm_oe_o
);
   localparam int NCH  = 2;
   localparam int TW   = $clog2(TICK_DIV);
   localparam int CW   = DLY_W + 1;

   initial begin
      a_word_fits: assert (FREQ_LSB + FREQ_W <= WORD_W && DUTY_W <= WORD_W)
         else $error("parameter fields exceed word width");
      a_tick_div: assert (TICK_DIV >= 2) else $error("TICK_DIV below 2");
      a_steps: assert (NSTEPS >= 2 && NSTEPS <= (1 << DUTY_W) * 4)
         else $error("NSTEPS out of range");
   end

   logic          run;
   logic [TW-1:0] tcnt_q;
   logic          tick;
   logic [2:0]    trig_sync_q;
   logic          rise, fall;

   assign run  = run_start_i & run_en_i;
   assign tick = (tcnt_q == TW'(TICK_DIV - 1));
   assign rise = run && trig_sync_q[1] && !trig_sync_q[2];
   assign fall = run && !trig_sync_q[1] && trig_sync_q[2];

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         tcnt_q      <= '0;
         trig_sync_q <= '0;
      end else begin
         tcnt_q      <= tick ? '0 : tcnt_q + TW'(1);
         trig_sync_q <= {trig_sync_q[1:0], trig_i};
      end
   end

   logic [CW-1:0]     dly [NCH];
   logic [NCH-1:0]    start;
   logic [NCH-1:0]    pwm_raw;
   logic [DUTY_W-1:0] duty [NCH];

   assign dly[0] = CW'(prm_dly0_i);
   assign dly[1] = CW'(prm_dly0_i) + CW'(prm_dly_com_i);

   generate
      for (genvar c = 0; c < NCH; c++) begin : g_ch
         fader_delay #(.CW(CW)) u_dly (
            .clk(clk), .rst_n(rst_n), .run(run), .tick(tick),
            .arm(rise), .cancel(fall), .dly(dly[c]), .fire(start[c])
         );
         fader_chan #(
            .NSTEPS(NSTEPS), .DUTY_W(DUTY_W), .SLEW_W(SLEW_W),
            .CURVE_SQUARE(CURVE_SQUARE)
         ) u_chan (
            .clk(clk), .rst_n(rst_n), .run(run), .tick(tick),
            .go_up(start[c]), .go_down(fall),
            .slew_up(prm_slew_up_i), .slew_dn(prm_slew_dn_i),
            .tgt_hi(prm_hi_i[DUTY_W-1:0]), .tgt_lo(prm_lo_i[DUTY_W-1:0]),
            .duty(duty[c])
         );
         fader_pwm #(.DUTY_W(DUTY_W), .FREQ_W(FREQ_W), .DIV_UNIT(DIV_UNIT)) u_pwm (
            .clk(clk), .rst_n(rst_n),
            .freq(prm_freq_i[FREQ_LSB +: FREQ_W]),
            .duty_in(duty[c]), .pwm(pwm_raw[c])
         );
      end
   endgenerate

   assign pwm_oe_o = mode_i;
   assign pwm_o    = mode_i ? pwm_raw : '0;

   // R10: programming mode leaves the pins quiet
   p_prog_quiet_r10: assert property (@(posedge clk) disable iff (!rst_n)
      !mode_i |-> (pwm_o == 2'b00) && !pwm_oe_o);

   // R8: a fall never coincides with a delayed start
   p_fall_cancels_r8: assert property (@(posedge clk) disable iff (!rst_n)
      fall |-> (start == '0));

endmodule

// File: tb/sim_fader_top.sv
module sim_fader_top;
   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        mode_i = 1'b1;
   logic        run_start_i = 1'b1;
   logic        run_en_i = 1'b1;
   logic        trig_i = 1'b0;
   logic [15:0] prm_lo_i = 16'd0;
   logic [15:0] prm_hi_i = 16'd127;
   logic [15:0] prm_freq_i = 16'd31 << 7;
   logic [15:0] prm_slew_up_i = 16'd0;
   logic [15:0] prm_slew_dn_i = 16'd0;
   logic [15:0] prm_dly0_i = 16'd0;
   logic [15:0] prm_dly_com_i = 16'd0;
   logic [1:0]  pwm_o;
   logic        pwm_oe_o;

   int checks = 0;
   int errors = 0;
   bit done = 1'b0;

   always #5 clk = ~clk;

   fader_top #(.TICK_DIV(4), .DIV_UNIT(1)) u0 (
      .clk(clk), .rst_n(rst_n), .mode_i(mode_i),
      .run_start_i(run_start_i), .run_en_i(run_en_i), .trig_i(trig_i),
      .prm_lo_i(prm_lo_i), .prm_hi_i(prm_hi_i), .prm_freq_i(prm_freq_i),
      .prm_slew_up_i(prm_slew_up_i), .prm_slew_dn_i(prm_slew_dn_i),
      .prm_dly0_i(prm_dly0_i), .prm_dly_com_i(prm_dly_com_i),
      .pwm_o(pwm_o), .pwm_oe_o(pwm_oe_o)
   );

   function automatic int curve(input int k);
      return (k * k * 127) / (175 * 175);
   endfunction

   function automatic int up_stop(input int t);
      for (int k = 0; k < 176; k++) if (curve(k) >= t) return curve(k);
      return 127;
   endfunction

   function automatic int down_stop(input int t, input int from);
      for (int k = from; k > 0; k--) if (curve(k) <= t) return curve(k);
      return 0;
   endfunction

   task automatic check(input string req, input int act, input int exp);
      checks++;
      if (act != exp) begin
         errors++;
         $display("FAIL %s: actual %0d expected %0d", req, act, exp);
      end
   endtask

   task automatic check_rng(input string req, input int act, input int lo, input int hi);
      checks++;
      if (act < lo || act > hi) begin
         errors++;
         $display("FAIL %s: actual %0d expected %0d..%0d", req, act, lo, hi);
      end
   endtask

   task automatic wait_cyc(input int n);
      repeat (n) @(negedge clk);
   endtask

   task automatic high_count(input int ch, input int n, output int hi);
      hi = 0;
      repeat (n) begin
         @(negedge clk);
         if (pwm_o[ch]) hi++;
      end
   endtask

   task automatic period_of_ch0(output int gap);
      bit prev;
      int seen;
      gap = 0; seen = 0;
      @(negedge clk); prev = pwm_o[0];
      for (int i = 0; i < 20000 && seen < 2; i++) begin
         @(negedge clk);
         if (seen == 1) gap++;
         if (pwm_o[0] && !prev) seen++;
         prev = pwm_o[0];
      end
   endtask

   initial begin
      int hi;
      int gap;
      int codes [3] = '{31, 29, 24};
      int maxes [5] = '{127, 100, 64, 20, 1};
      int mins  [2] = '{50, 5};

      wait_cyc(5);
      rst_n = 1'b1;
      wait_cyc(2);
      // R1: reset state
      check("R1 pwm after reset", int'(pwm_o), 0);
      check("R1 oe follows mode", int'(pwm_oe_o), 1);
      high_count(0, 127, hi);
      check("R1 idle duty", hi, 0);

      // R3 / R4 / R2: sweep of high level, then back to 0
      foreach (maxes[i]) begin
         prm_hi_i = 16'(maxes[i]);
         trig_i = 1'b1; wait_cyc(1200);
         high_count(0, 127, hi);
         check($sformatf("R3 R2 ch0 high level %0d", maxes[i]), hi, up_stop(maxes[i]));
         high_count(1, 127, hi);
         check($sformatf("R3 ch1 high level %0d", maxes[i]), hi, up_stop(maxes[i]));
         trig_i = 1'b0; wait_cyc(1200);
         high_count(0, 127, hi);
         check($sformatf("R4 back to low from %0d", maxes[i]), hi, 0);
      end

      // R4: low level sweep from full scale
      prm_hi_i = 16'd127;
      foreach (mins[i]) begin
         prm_lo_i = 16'(mins[i]);
         trig_i = 1'b1; wait_cyc(1200);
         trig_i = 1'b0; wait_cyc(1200);
         high_count(1, 127, hi);
         check($sformatf("R4 low level %0d", mins[i]), hi, down_stop(mins[i], 175));
      end
      prm_lo_i = 16'd0;
      wait_cyc(1200);

      // R5: period for several codes at mid duty
      prm_hi_i = 16'd64;
      trig_i = 1'b1; wait_cyc(1200);
      foreach (codes[i]) begin
         prm_freq_i = 16'(codes[i] << 7);
         wait_cyc(127 * (32 - codes[i]) * 3);
         period_of_ch0(gap);
         check($sformatf("R5 period code %0d", codes[i]), gap, 127 * (32 - codes[i]));
      end
      prm_freq_i = 16'd31 << 7;
      wait_cyc(3000);
      high_count(0, 127, hi);
      check("R5 R6 duty slots at code 31", hi, up_stop(64));

      // R10: programming mode
      mode_i = 1'b0; wait_cyc(2);
      check("R10 oe low", int'(pwm_oe_o), 0);
      high_count(0, 254, hi);
      check("R10 outputs quiet", hi, 0);
      mode_i = 1'b1;
      trig_i = 1'b0; wait_cyc(1200);
      prm_hi_i = 16'd127;

      // R9: halted fader ignores edges, none replayed
      run_en_i = 1'b0;
      trig_i = 1'b1; wait_cyc(1200);
      high_count(0, 127, hi);
      check("R9 halted no fade", hi, 0);
      run_en_i = 1'b1; wait_cyc(1200);
      high_count(0, 127, hi);
      check("R9 no replay after resume", hi, 0);
      trig_i = 1'b0; wait_cyc(20);

      // R8: staggered start
      prm_dly0_i = 16'd250;
      prm_dly_com_i = 16'd400;
      trig_i = 1'b1; wait_cyc(500);
      high_count(0, 127, hi);
      check("R8 ch0 waits for delay", hi, 0);
      wait_cyc(1273);
      high_count(0, 127, hi);
      check("R8 ch0 done after delay", hi, 127);
      high_count(1, 127, hi);
      check("R8 ch1 still waiting", hi, 0);
      wait_cyc(1500);
      high_count(1, 127, hi);
      check("R8 ch1 done after both delays", hi, 127);
      trig_i = 1'b0; wait_cyc(1200);
      // fall cancels a pending start
      trig_i = 1'b1; wait_cyc(200);
      trig_i = 1'b0; wait_cyc(3500);
      high_count(1, 127, hi);
      check("R8 fall cancels pending start", hi, 0);
      prm_dly0_i = 16'd0;
      prm_dly_com_i = 16'd0;

      // R7: slow rise slew
      prm_slew_up_i = 16'd9;
      trig_i = 1'b1; wait_cyc(1000);
      high_count(0, 127, hi);
      check_rng("R7 slow rise still low", hi, 0, 10);
      wait_cyc(7000);
      high_count(0, 127, hi);
      check("R7 slow rise completes", hi, 127);
      trig_i = 1'b0; wait_cyc(1200);
      high_count(0, 127, hi);
      check("R7 fast fall completes", hi, 0);

      // R11: reversal mid-fade continues from current step
      prm_slew_up_i = 16'd19;
      prm_slew_dn_i = 16'd199;
      trig_i = 1'b1; wait_cyc(8000);
      trig_i = 1'b0; wait_cyc(200);
      high_count(0, 127, hi);
      check_rng("R11 reversal from current step", hi, 20, 70);
      prm_slew_dn_i = 16'd0;
      wait_cyc(1500);
      high_count(0, 127, hi);
      check("R11 R7 slew change applies mid-step", hi, 0);

      done = 1'b1;
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
   end

   initial begin
      repeat (150000) @(posedge clk);
      if (!done) begin
         checks++;
         errors++;
         $display("FAIL watchdog: actual timeout expected completion");
         $display("Simulation finished: %0d checks, %0d errors", checks, errors);
         $finish;
      end
   end

endmodule